// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block is a two-clock FIFO for 36-bit words with 256 memory locations and a separate output register that presents data on the read port. Port A writes on its own clock and port B reads on an unrelated clock. Each port is qualified by an active-low chip select, a direction select, an enable and a mailbox select that must be low for a FIFO transfer. The block also drives a data output-enable for each port, decoded from that port's chip select and direction select.

The read side works in one of two styles, picked by `fwft_sel` while port B is in reset. In standard style the port B flag is an empty flag, and a word reaches the output register only when a read is requested. In fall-through style the flag means "output ready": the first word of an idle FIFO is moved into the output register without a request, and further words move only on requested reads. The word held in the output register does not occupy a memory location. As a result, fall-through style can accept one more word than the memory holds before it reports full.

Pointers cross between the clocks as Gray codes through two-stage synchronizers. The write-side full flag belongs to the port A clock and the read-side flag to the port B clock.

Top module: `dcfifo_fwft`

## Requirements
- R1: A word is written on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mb`=0 and `a_ir`=1. With any one of these conditions missing, nothing is stored.
- R2: A read on a rising `clk_b` edge needs `b_cs_n`=0, `b_rd`=1, `b_en`=1, `b_mb`=0 and `b_flag`=1. A read attempted while `b_flag`=0 is ignored, and `b_dout` keeps the previous word.
- R3: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_wr`=0. `b_oe` is 1 exactly when `b_cs_n`=0 and `b_rd`=1.
- R4: In fall-through style, a word written while `b_flag`=0 appears on `b_dout` on the third rising `clk_b` edge after the write edge. `b_flag` rises on that same edge and stays 0 after the first and second edges.
- R5: In fall-through style with `b_flag`=1, `b_dout` changes only on a selected read. A selected read that finds the memory empty drops `b_flag` to 0 and leaves `b_dout` unchanged.
- R6: In standard style, `b_flag` (empty flag, 1 = data in memory) goes to 1 on the second rising `clk_b` edge after the first write into an empty memory. `b_dout` changes only on a selected read, which loads the oldest word.
- R7: `a_ir` goes low on the write edge that fills all 256 memory locations and rises again within a few `clk_a` cycles after a read frees one. The word in the output register is not counted, so fall-through style accepts 257 words before stalling.
- R8: Reset (`rst_a`, `rst_b`, synchronous, active high) empties the FIFO, drives `a_ir`=1, `b_flag`=0 and `b_dout`=0, and latches `fwft_sel` (1 = fall-through). Later changes of `fwft_sel` have no effect until the next reset.
- R9: Words leave in the order they were written, across both clock domains, and no more than 256 words are ever counted in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-port clock |
| rst_a | input | 1 | Synchronous reset, port A domain |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 = write |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A mailbox select; must be 0 for FIFO writes |
| a_din | input | 36 | Write data |
| a_ir | output | 1 | Full/input-ready flag, 1 = space available |
| a_oe | output | 1 | Port A data output-enable |
| clk_b | input | 1 | Read-port clock |
| rst_b | input | 1 | Synchronous reset, port B domain |
| fwft_sel | input | 1 | Read style sampled at reset: 1 = fall-through, 0 = standard |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_rd | input | 1 | Port B direction: 1 = read |
| b_en | input | 1 | Port B enable |
| b_mb | input | 1 | Port B mailbox select; must be 0 for FIFO reads |
| b_dout | output | 36 | Output register contents |
| b_flag | output | 1 | Empty flag (standard) or output-ready (fall-through) |
| b_oe | output | 1 | Port B data output-enable |

## Verification
The bench builds the block with its default parameters, 36-bit words and an 8-bit address. At this size the full 256-location boundary can be filled completely in both read styles, so the 256-versus-257 capacity difference caused by the output register can be observed. The port B clock runs at the same rate as port A but with a fixed phase offset. This keeps the two- and three-edge flag latencies at fixed, countable edges, and every pointer still passes through the Gray synchronizers.

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft #(
  parameter int WIDTH  = 36,
  parameter int ADDR_W = 8
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             a_cs_n,
  input  logic             a_wr,
  input  logic             a_en,
  input  logic             a_mb,
  input  logic [WIDTH-1:0] a_din,
  output logic             a_ir,
  output logic             a_oe,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             fwft_sel,
  input  logic             b_cs_n,
  input  logic             b_rd,
  input  logic             b_en,
  input  logic             b_mb,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_flag,
  output logic             b_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // ---------------- port A (write) domain ----------------
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic          wr_go;

  assign a_oe  = !a_cs_n && !a_wr;
  assign a_ir  = wgray != {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]};
  assign wr_go = !a_cs_n && a_wr && a_en && !a_mb && a_ir;

  logic [PW-1:0] rgray;

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= bin2gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge clk_a)
    if (wr_go) mem[wbin[ADDR_W-1:0]] <= a_din;

  logic [PW-1:0] rbin_at_a;
  assign rbin_at_a = gray2bin(rg_s2);

  assert_depth_bound_a_R7: assert property (@(posedge clk_a) disable iff (rst_a)
    (PW'(wbin - rbin_at_a) <= PW'(DEPTH)));

  // ---------------- port B (read) domain ----------------
  logic [PW-1:0]    rbin, wg_s1, wg_s2;
  logic             fwft_q, or_q, mem_ne, rd_sel, load;
  logic [WIDTH-1:0] dout_q;

  assign b_oe   = !b_cs_n && b_rd;
  assign mem_ne = rgray != wg_s2;
  assign rd_sel = !b_cs_n && b_rd && b_en && !b_mb;
  assign b_flag = fwft_q ? or_q : mem_ne;
  assign load   = fwft_q ? (mem_ne && (!or_q || rd_sel)) : (rd_sel && mem_ne);
  assign b_dout = dout_q;

  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      fwft_q <= fwft_sel;
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      or_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      or_q  <= fwft_q && (load || (or_q && !rd_sel));
      if (load) begin
        dout_q <= mem[rbin[ADDR_W-1:0]];
        rbin   <= rbin + 1'b1;
        rgray  <= bin2gray(rbin + 1'b1);
      end
    end
  end

  logic [PW-1:0] wbin_at_b;
  assign wbin_at_b = gray2bin(wg_s2);

  assert_no_underrun_R9: assert property (@(posedge clk_b) disable iff (rst_b)
    (PW'(wbin_at_b - rbin) <= PW'(DEPTH)));

  assert_hold_when_empty_R2: assert property (@(posedge clk_b) disable iff (rst_b)
    (!fwft_q && !b_flag) |=> $stable(b_dout));

  assert_ready_holds_R5: assert property (@(posedge clk_b) disable iff (rst_b)
    (fwft_q && b_flag && !rd_sel) |=> (b_flag && $stable(b_dout)));

  assert_mode_fixed_R8: assert property (@(posedge clk_b) disable iff (rst_b)
    !$fell(rst_b) |-> $stable(fwft_q));
endmodule

// File: tb/dcfifo_fwft_bench.sv
`timescale 1ns/1ps
module dcfifo_fwft_bench;
  logic clk_a = 0, clk_b = 0;
  logic rst_a = 1, rst_b = 1, fwft_sel = 0;
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic b_cs_n = 1, b_rd = 0, b_en = 0, b_mb = 0;
  logic [35:0] a_din = '0;
  logic [35:0] b_dout;
  logic a_ir, a_oe, b_flag, b_oe;
  int checks = 0, fails = 0;

  always #4 clk_a = ~clk_a;
  initial begin #3; forever #4 clk_b = ~clk_b; end

  dcfifo_fwft u_dcfifo_fwft (.*);

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit fw);
    rst_a = 1; rst_b = 1; fwft_sel = fw;
    a_en = 0; b_en = 0; a_cs_n = 1; b_cs_n = 1; a_mb = 0; b_mb = 0;
    repeat (4) @(posedge clk_a);
    @(negedge clk_a) rst_a = 0;
    @(negedge clk_b) rst_b = 0;
    #1;
    chk(a_ir == 1, "R8 ir after reset", 36'(a_ir), 1);
    chk(b_flag == 0, "R8 flag after reset", 36'(b_flag), 0);
    chk(b_dout == 0, "R8 dout after reset", b_dout, 0);
  endtask

  task automatic write_try(input logic [35:0] d, input bit cs_n, input bit wr, input bit en, input bit mb);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mb = mb; a_din = d;
    @(posedge clk_a); #1;
    a_en = 0; a_cs_n = 1;
  endtask

  task automatic write_word(input logic [35:0] d);
    write_try(d, 0, 1, 1, 0);
  endtask

  task automatic read_try(input bit cs_n, input bit rd, input bit en, input bit mb);
    @(negedge clk_b);
    b_cs_n = cs_n; b_rd = rd; b_en = en; b_mb = mb;
    @(posedge clk_b); #1;
    b_en = 0; b_cs_n = 1;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  task automatic t_fwft_latency;
    do_reset(1);
    fwft_sel = 0;
    write_word(36'hA_1111_0001);
    wait_b(1); chk(b_flag == 0, "R4 flag after edge 1", 36'(b_flag), 0);
    wait_b(1); chk(b_flag == 0, "R4 flag after edge 2", 36'(b_flag), 0);
    wait_b(1);
    chk(b_flag == 1, "R4 flag after edge 3", 36'(b_flag), 1);
    chk(b_dout == 36'hA_1111_0001, "R4 word after edge 3", b_dout, 36'hA_1111_0001);
    write_word(36'hA_2222_0002);
    wait_b(5);
    chk(b_dout == 36'hA_1111_0001, "R5 no advance without read", b_dout, 36'hA_1111_0001);
    chk(b_flag == 1, "R8 mode kept after fwft_sel change", 36'(b_flag), 1);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'hA_2222_0002, "R5 read advances", b_dout, 36'hA_2222_0002);
    read_try(0, 1, 1, 0);
    chk(b_flag == 0, "R5 flag drops on last read", 36'(b_flag), 0);
    chk(b_dout == 36'hA_2222_0002, "R5 dout kept on last read", b_dout, 36'hA_2222_0002);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'hA_2222_0002, "R2 read ignored when not ready", b_dout, 36'hA_2222_0002);
  endtask

  task automatic t_std;
    do_reset(0);
    read_try(0, 1, 1, 0);
    chk(b_dout == 0, "R2 read ignored when empty", b_dout, 0);
    write_word(36'h5_0000_0010);
    wait_b(1); chk(b_flag == 0, "R6 flag after edge 1", 36'(b_flag), 0);
    wait_b(1); chk(b_flag == 1, "R6 flag after edge 2", 36'(b_flag), 1);
    chk(b_dout == 0, "R6 no unrequested load", b_dout, 0);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'h5_0000_0010, "R6 read loads word", b_dout, 36'h5_0000_0010);
    chk(b_flag == 0, "R6 empty after read", 36'(b_flag), 0);
    write_word(36'h5_0000_0011);
    write_word(36'h5_0000_0012);
    wait_b(4);
    read_try(1, 1, 1, 0); read_try(0, 0, 1, 0); read_try(0, 1, 0, 0); read_try(0, 1, 1, 1);
    chk(b_dout == 36'h5_0000_0010, "R2 unqualified reads ignored", b_dout, 36'h5_0000_0010);
    chk(b_flag == 1, "R2 data still present", 36'(b_flag), 1);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'h5_0000_0011, "R9 order word 1", b_dout, 36'h5_0000_0011);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'h5_0000_0012, "R9 order word 2", b_dout, 36'h5_0000_0012);
  endtask

  task automatic t_write_qual;
    do_reset(0);
    write_try(36'h1, 1, 1, 1, 0);
    write_try(36'h2, 0, 0, 1, 0);
    write_try(36'h3, 0, 1, 0, 0);
    write_try(36'h4, 0, 1, 1, 1);
    wait_b(5);
    chk(b_flag == 0, "R1 unqualified writes ignored", 36'(b_flag), 0);
    write_word(36'h7);
    wait_b(3);
    chk(b_flag == 1, "R1 qualified write stored", 36'(b_flag), 1);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'h7, "R1 stored value", b_dout, 36'h7);
  endtask

  task automatic t_oe;
    for (int i = 0; i < 4; i++) begin
      a_en = 0; b_en = 0;
      a_cs_n = i[0]; a_wr = i[1]; b_cs_n = i[0]; b_rd = i[1];
      #1;
      chk(a_oe == (!i[0] && !i[1]), "R3 a_oe decode", 36'(a_oe), 36'(!i[0] && !i[1]));
      chk(b_oe == (!i[0] && i[1]), "R3 b_oe decode", 36'(b_oe), 36'(!i[0] && i[1]));
    end
    a_cs_n = 1; b_cs_n = 1;
  endtask

  task automatic t_full_std;
    int bad = 0;
    do_reset(0);
    for (int i = 0; i < 256; i++) begin
      if (!a_ir) bad++;
      write_word(36'(100 + i));
    end
    chk(bad == 0, "R7 ir high before 256 words", 36'(bad), 0);
    chk(a_ir == 0, "R7 ir low at 256 words", 36'(a_ir), 0);
    write_word(36'd999);
    wait_b(3);
    read_try(0, 1, 1, 0);
    chk(b_dout == 36'd100, "R9 first word out", b_dout, 36'd100);
    repeat (4) @(posedge clk_a);
    #1;
    chk(a_ir == 1, "R7 ir recovers after read", 36'(a_ir), 1);
    bad = 0;
    for (int i = 1; i < 256; i++) begin
      read_try(0, 1, 1, 0);
      if (b_dout != 36'(100 + i)) bad++;
    end
    chk(bad == 0, "R9 drain order standard", 36'(bad), 0);
    wait_b(2);
    chk(b_flag == 0, "R1 write while full ignored", 36'(b_flag), 0);
  endtask

  task automatic t_full_fwft;
    int acc = 0, bad = 0;
    do_reset(1);
    for (int t = 0; t < 400 && acc < 257; t++) begin
      @(negedge clk_a);
      a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 0; a_din = 36'(acc);
      if (a_ir) begin
        @(posedge clk_a);
        acc++;
      end else @(posedge clk_a);
    end
    #1; a_en = 0; a_cs_n = 1;
    chk(acc == 257, "R7 fwft accepts 257 words", 36'(acc), 257);
    repeat (6) @(posedge clk_a);
    #1;
    chk(a_ir == 0, "R7 fwft full with 256 in memory", 36'(a_ir), 0);
    for (int i = 0; i < 257; i++) begin
      #1;
      if (b_dout != 36'(i) || !b_flag) bad++;
      read_try(0, 1, 1, 0);
    end
    chk(bad == 0, "R9 drain order fwft", 36'(bad), 0);
    chk(b_flag == 0, "R5 ready low after drain", 36'(b_flag), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_oe();
    t_fwft_latency();
    t_std();
    t_write_qual();
    t_full_std();
    t_full_fwft();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule